// File: doc/BRIEF.md
# Single-Wire Debug Bit Transceiver

This block is the target-side bit engine of a one-wire debug link in which the host times every bit. The pad is modelled as open-drain with a weak pull-up and seen through three signals: the raw line level coming in, an enable that pulls the line low, and an enable that drives it high for a short moment. The host opens every bit with a falling edge, whichever way the data flows. All timing inside the block is counted in target clock cycles from the cycle in which that edge is recognised.

In receive mode the block reads the line part way through each bit and shifts the value in. In transmit mode it either holds the line low and then pulses it high, or releases it at once and pulses it high early. Because the target drives that pulse, the line returns to logic 1 faster than the pull-up alone would allow. A shift register and bit counter give a one-cycle done strobe after a byte or a 16-bit word. If the host stops sending edges part way through a transfer, the block drops the partial transfer and gives a one-cycle timeout strobe.

Top module: `dbg_bit_link`

## Requirements
- R1: When reset is released, `pad_pull_low`, `pad_push_high`, `xfer_done`, `link_timeout` are 0 and `rx_data` is 0.
- R2: In receive mode (`dir_tx`=0) with `len_word`=0, `xfer_done` rises after the 8th host bit. `rx_data` then holds the byte in bits 7..0, with the first bit received in bit 7, and zeros in bits 15..8.
- R3: In receive mode with `len_word`=1, `xfer_done` rises after the 16th host bit. `rx_data` then holds the word, with the first bit received in bit 15.
- R4: A received bit is the synchronized line level 10 cycles after the detected falling edge: low gives 0 and high gives 1.
- R5: When transmitting a 0, `pad_pull_low` is asserted for detected-edge ages 1 through 12. `pad_push_high` is asserted for exactly one cycle at age 13, in the cycle right after the low ends.
- R6: When transmitting a 1, `pad_pull_low` stays 0 and `pad_push_high` is asserted for exactly one cycle at age 4.
- R7: A pulse on `tx_load` loads `tx_data`. Transmission is most significant bit first: bit 7 first for a byte, bit 15 first for a word. `xfer_done` pulses after the last bit.
- R8: `pad_pull_low` and `pad_push_high` are never asserted together. In receive mode neither is ever asserted.
- R9: When a transfer is under way and 512 cycles pass after a detected falling edge with no further edge, `link_timeout` pulses for one cycle. The partial bits are discarded, so a full 8 or 16 new bits are needed before the next `xfer_done`.
- R10: No timeout occurs while edges arrive less than 512 cycles apart, nor while the link is idle between transfers.
- R11: `xfer_done` and `link_timeout` are each single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Raw level of the debug line, asynchronous |
| dir_tx | input | 1 | 1 = send to host, 0 = receive from host |
| len_word | input | 1 | 1 = 16-bit transfer, 0 = 8-bit transfer |
| tx_load | input | 1 | One-cycle strobe that loads `tx_data` and clears the bit count |
| tx_data | input | 16 | Data to send |
| rx_data | output | 16 | Received data, valid while `xfer_done` is high |
| xfer_done | output | 1 | One-cycle strobe when the selected number of bits is complete |
| link_timeout | output | 1 | One-cycle strobe when a partial transfer is abandoned |
| pad_pull_low | output | 1 | Enable that pulls the line low |
| pad_push_high | output | 1 | Enable that drives the brief speedup high |

## Verification
The assertions assume that `dir_tx` and `len_word` stay fixed for a whole transfer. They also assume that `tx_load` is pulsed only between bits, and that the host leaves at least 16 cycles between falling edges so that bit windows never overlap. In every task of the bench the direction, length and load are set before the first host edge. Host edges are spaced 20 cycles apart or more. In transmit bits the host holds the line low until after the target has taken it over, so that no false edge appears.

// File: rtl/dbg_link_pkg.sv
// Shared types for the single-wire debug bit transceiver.
// Assumes: nothing beyond standard SystemVerilog.
package dbg_link_pkg;

    // Direction of the current transfer as seen from the target.
    typedef enum logic {
        LINK_RX = 1'b0,
        LINK_TX = 1'b1
    } link_dir_t;

    // Events inside one bit window, produced by the bit timer.
    typedef struct packed {
        logic sample;   // receive sampling point reached
        logic finish;   // last cycle of the bit window
    } bit_evt_t;

endpackage

// File: rtl/dbg_line_sync.sv
// Brings the asynchronous line level into the clock domain through two flops
// and flags a falling edge (previous sample high, current sample low).
// Assumes: the line idles high, so all stages reset to 1.
module dbg_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Synchronizer chain plus one-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_s = sync_q;
    assign fall   = prev_q & ~sync_q;

endmodule

// File: rtl/dbg_bit_timer.sv
// Counts the age of the current bit window in target cycles. The cycle in which
// the edge is detected is age 0, and the counter shows age 1 on the next cycle.
// Assumes: a new edge always restarts the window, even inside an open one.
module dbg_bit_timer
    import dbg_link_pkg::*;
#(
    parameter int BIT_CYC   = 16,
    parameter int RX_SAMPLE = 10,
    localparam int AGE_W    = $clog2(BIT_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    output logic             busy,
    output logic [AGE_W-1:0] age,
    output bit_evt_t         evt
);

    // Window age counter: start on an edge, stop after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            age  <= '0;
        end else if (fall) begin
            busy <= 1'b1;
            age  <= AGE_W'(1);
        end else if (busy) begin
            if (age == AGE_W'(BIT_CYC - 1)) begin
                busy <= 1'b0;
            end else begin
                age <= age + AGE_W'(1);
            end
        end
    end

    assign evt.sample = busy && (age == AGE_W'(RX_SAMPLE));
    assign evt.finish = busy && (age == AGE_W'(BIT_CYC - 1));

endmodule

// File: rtl/dbg_link_watch.sv
// Link watchdog: counts cycles since the last detected edge while a transfer
// is under way and fires when the limit is reached.
// Assumes: mid_xfer is low between transfers, so an idle link never expires.
module dbg_link_watch #(
    parameter int TIMEOUT_CYC = 512,
    localparam int TO_W       = $clog2(TIMEOUT_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic mid_xfer,
    output logic fire,
    output logic timeout
);

    logic [TO_W-1:0] idle_q;

    assign fire = mid_xfer && !fall && (idle_q == TO_W'(TIMEOUT_CYC - 1));

    // Idle counter: cleared by an edge, by expiry or while no transfer is open.
    always_ff @(posedge clk) begin
        if (!rst_n || fall || fire || !mid_xfer) begin
            idle_q <= '0;
        end else begin
            idle_q <= idle_q + TO_W'(1);
        end
    end

    // Registered one-cycle timeout strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout <= 1'b0;
        end else begin
            timeout <= fire;
        end
    end

endmodule

// File: rtl/dbg_bit_shifter.sv
// Shift register and bit counter for both directions, plus the pad drive
// pattern for transmit. Receive shifts at the sample point and transmit
// shifts at the end of the window. Data goes most significant bit first.
// Assumes: dir_tx and len_word are stable for a whole transfer.
module dbg_bit_shifter
    import dbg_link_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int BIT_CYC     = 16,
    parameter int TX0_RELEASE = 13,
    parameter int TX1_PULSE   = 4,
    localparam int AGE_W      = $clog2(BIT_CYC),
    localparam int BC_W       = $clog2(WORD_W + 1),
    localparam int HALF_W     = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  link_dir_t         dir,
    input  logic              len_word,
    input  logic              tx_load,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              line_s,
    input  logic              busy,
    input  logic [AGE_W-1:0]  age,
    input  bit_evt_t          evt,
    input  logic              abort,
    output logic [WORD_W-1:0] rx_data,
    output logic              in_xfer,
    output logic              done,
    output logic              pull_low,
    output logic              push_high
);

    logic [WORD_W-1:0] sh_q;
    logic [BC_W-1:0]   bc_q;
    logic [BC_W-1:0]   last_bit;
    logic              step;
    logic              cur_bit;
    logic              tx_win;

    assign last_bit = len_word ? BC_W'(WORD_W - 1) : BC_W'(HALF_W - 1);
    assign step     = (dir == LINK_TX) ? evt.finish : evt.sample;
    assign cur_bit  = len_word ? sh_q[WORD_W-1] : sh_q[HALF_W-1];
    assign tx_win   = (dir == LINK_TX) && busy;
    assign in_xfer  = (bc_q != '0);

    // Shift and count: abort wins, then load, then a bit step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            bc_q <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                sh_q <= '0;
                bc_q <= '0;
            end else if (tx_load) begin
                sh_q <= tx_data;
                bc_q <= '0;
            end else if (step) begin
                sh_q <= {sh_q[WORD_W-2:0], (dir == LINK_RX) ? line_s : 1'b0};
                if (bc_q == last_bit) begin
                    bc_q <= '0;
                    done <= 1'b1;
                end else begin
                    bc_q <= bc_q + BC_W'(1);
                end
            end
        end
    end

    // Received data, with the upper half masked for byte transfers.
    always_comb begin
        rx_data = sh_q;
        if (!len_word) begin
            rx_data[WORD_W-1:HALF_W] = '0;
        end
    end

    // Pad drive pattern for the bit being sent.
    always_comb begin
        pull_low  = tx_win && !cur_bit && (age < AGE_W'(TX0_RELEASE));
        push_high = tx_win && (cur_bit ? (age == AGE_W'(TX1_PULSE))
                                       : (age == AGE_W'(TX0_RELEASE)));
    end

endmodule

// File: rtl/dbg_bit_link.sv
// Top of the single-wire debug bit transceiver. It joins the line
// synchronizer, the bit timer, the shifter and the link watchdog.
// Assumes: the pad is open-drain with a pull-up, and the host starts every
// bit with a falling edge at least BIT_CYC cycles after the previous one.
module dbg_bit_link
    import dbg_link_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int BIT_CYC     = 16,
    parameter int RX_SAMPLE   = 10,
    parameter int TX0_RELEASE = 13,
    parameter int TX1_PULSE   = 4,
    parameter int TIMEOUT_CYC = 512,
    localparam int AGE_W      = $clog2(BIT_CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              dir_tx,
    input  logic              len_word,
    input  logic              tx_load,
    input  logic [WORD_W-1:0] tx_data,
    output logic [WORD_W-1:0] rx_data,
    output logic              xfer_done,
    output logic              link_timeout,
    output logic              pad_pull_low,
    output logic              pad_push_high
);

    logic             line_s;
    logic             fall;
    logic             busy;
    logic [AGE_W-1:0] age;
    bit_evt_t         evt;
    logic             in_xfer;
    logic             fire;
    link_dir_t        dir;

    assign dir = dir_tx ? LINK_TX : LINK_RX;

    dbg_line_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .line_s (line_s),
        .fall   (fall)
    );

    dbg_bit_timer #(
        .BIT_CYC  (BIT_CYC),
        .RX_SAMPLE(RX_SAMPLE)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .fall (fall),
        .busy (busy),
        .age  (age),
        .evt  (evt)
    );

    dbg_bit_shifter #(
        .WORD_W     (WORD_W),
        .BIT_CYC    (BIT_CYC),
        .TX0_RELEASE(TX0_RELEASE),
        .TX1_PULSE  (TX1_PULSE)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir      (dir),
        .len_word (len_word),
        .tx_load  (tx_load),
        .tx_data  (tx_data),
        .line_s   (line_s),
        .busy     (busy),
        .age      (age),
        .evt      (evt),
        .abort    (fire),
        .rx_data  (rx_data),
        .in_xfer  (in_xfer),
        .done     (xfer_done),
        .pull_low (pad_pull_low),
        .push_high(pad_push_high)
    );

    dbg_link_watch #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall    (fall),
        .mid_xfer(in_xfer || busy),
        .fire    (fire),
        .timeout (link_timeout)
    );

endmodule

// File: rtl/dbg_bit_link_chk.sv
// Checker for the bit transceiver's port behaviour, bound to the top module.
// Assumes: dir_tx is stable across a transfer and tx_load comes between bits.
module dbg_bit_link_chk (
    input logic clk,
    input logic rst_n,
    input logic dir_tx,
    input logic tx_load,
    input logic xfer_done,
    input logic link_timeout,
    input logic pad_pull_low,
    input logic pad_push_high
);

    assert_drive_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pad_pull_low && pad_push_high));

    assert_rx_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_tx |-> (!pad_pull_low && !pad_push_high));

    assert_speedup_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pad_push_high |=> !pad_push_high);

    assert_low_then_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_tx && $past(dir_tx) && !$past(tx_load) && $fell(pad_pull_low)) |-> pad_push_high);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    assert_timeout_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        link_timeout |=> !link_timeout);

    assert_done_timeout_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && link_timeout));

endmodule

bind dbg_bit_link dbg_bit_link_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_tx       (dir_tx),
    .tx_load      (tx_load),
    .xfer_done    (xfer_done),
    .link_timeout (link_timeout),
    .pad_pull_low (pad_pull_low),
    .pad_push_high(pad_push_high)
);

// File: tb/tb_dbg_bit_link.sv
// Directed bench for the bit transceiver: one task per scenario, host modelled
// on an open-drain line. Inputs change on falling clock edges and outputs are
// read there too.
module tb_dbg_bit_link;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_low = 1'b0;
    logic        dir_tx = 1'b0;
    logic        len_word = 1'b0;
    logic        tx_load = 1'b0;
    logic [15:0] tx_data = '0;
    logic [15:0] rx_data;
    logic        xfer_done;
    logic        link_timeout;
    logic        pad_pull_low;
    logic        pad_push_high;
    logic        line;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int to_cnt = 0;
    int rx_drive_cnt = 0;
    logic [15:0] done_word = '0;

    always #5 clk = ~clk;

    // Open-drain line: low if anyone pulls low, otherwise high.
    assign line = !(host_low || pad_pull_low);

    dbg_bit_link dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_in      (line),
        .dir_tx       (dir_tx),
        .len_word     (len_word),
        .tx_load      (tx_load),
        .tx_data      (tx_data),
        .rx_data      (rx_data),
        .xfer_done    (xfer_done),
        .link_timeout (link_timeout),
        .pad_pull_low (pad_pull_low),
        .pad_push_high(pad_push_high)
    );

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_done) begin
                done_cnt  = done_cnt + 1;
                done_word = rx_data;
            end
            if (link_timeout) to_cnt = to_cnt + 1;
            if (!dir_tx && (pad_pull_low || pad_push_high)) rx_drive_cnt = rx_drive_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Host sends one bit: low for 4 cycles (1) or 13 cycles (0), 20-cycle period.
    task automatic host_send(input logic b);
        @(negedge clk);
        host_low = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (i == (b ? 4 : 13)) host_low = 1'b0;
        end
    endtask

    // Host reads one bit: short low, then sample the line at cycle 8.
    task automatic host_read(output logic b, output int lows, output int highs, output int hpos);
        lows = 0; highs = 0; hpos = 0; b = 1'b0;
        @(negedge clk);
        host_low = 1'b1;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (i == 4) host_low = 1'b0;
            if (i == 8) b = line;
            if (pad_pull_low) lows = lows + 1;
            if (pad_push_high) begin
                highs = highs + 1;
                hpos = i;
            end
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pull_low", pad_pull_low, 0);
        chk("R1 push_high", pad_push_high, 0);
        chk("R1 done", xfer_done, 0);
        chk("R1 timeout", link_timeout, 0);
        chk("R1 rx_data", rx_data, 0);
    endtask

    task automatic t_rx(input logic word, input logic [15:0] val, input string req);
        int n;
        int d0;
        n = word ? 16 : 8;
        dir_tx = 1'b0;
        len_word = word;
        d0 = done_cnt;
        for (int k = n - 1; k >= 0; k--) begin
            host_send(val[k]);
            if (k == 1) chk({req, " no early done"}, done_cnt - d0, 0);
        end
        chk({req, " done count"}, done_cnt - d0, 1);
        chk({req, " R4 data"}, done_word, word ? val : {8'h00, val[7:0]});
    endtask

    task automatic t_tx(input logic word, input logic [15:0] val);
        logic b;
        int lows, highs, hpos, n, d0;
        n = word ? 16 : 8;
        dir_tx = 1'b1;
        len_word = word;
        @(negedge clk);
        tx_data = val;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        d0 = done_cnt;
        for (int k = n - 1; k >= 0; k--) begin
            host_read(b, lows, highs, hpos);
            chk("R7 bit value", b, val[k]);
            chk(val[k] ? "R6 low count" : "R5 low count", lows, val[k] ? 0 : 12);
            chk(val[k] ? "R6 high count" : "R5 high count", highs, 1);
            chk(val[k] ? "R6 high position" : "R5 high position", hpos, val[k] ? 6 : 15);
        end
        chk("R7 done count", done_cnt - d0, 1);
        dir_tx = 1'b0;
    endtask

    task automatic t_timeout;
        int first;
        int t0;
        int d0;
        dir_tx = 1'b0;
        len_word = 1'b0;
        t0 = to_cnt;
        first = 0;
        host_send(1'b1);
        host_send(1'b0);
        @(negedge clk);
        host_low = 1'b1;
        for (int j = 1; j <= 600; j++) begin
            @(negedge clk);
            if (j == 4) host_low = 1'b0;
            if (link_timeout && first == 0) first = j;
        end
        chk("R9 timeout once", to_cnt - t0, 1);
        chk("R9 timeout late enough", (first >= 512) ? 1 : 0, 1);
        chk("R9 timeout on time", (first <= 520) ? 1 : 0, 1);
        d0 = done_cnt;
        t_rx(1'b0, 16'h0096, "R9 after abort");
        chk("R9 single done after abort", done_cnt - d0, 1);
    endtask

    task automatic t_slow_link;
        int t0;
        logic [7:0] v;
        v = 8'h5C;
        dir_tx = 1'b0;
        len_word = 1'b0;
        t0 = to_cnt;
        for (int k = 7; k >= 0; k--) begin
            host_send(v[k]);
            repeat (380) @(negedge clk);
        end
        chk("R10 slow bits data", done_word, {8'h00, v});
        chk("R10 no timeout slow", to_cnt - t0, 0);
        repeat (700) @(negedge clk);
        chk("R10 no timeout idle", to_cnt - t0, 0);
    endtask

    initial begin
        t_reset();
        t_rx(1'b0, 16'h00A3, "R2 byte");
        t_rx(1'b0, 16'hFF3C, "R2 byte masked");
        t_rx(1'b1, 16'hB2E1, "R3 word");
        chk("R8 no drive in rx", rx_drive_cnt, 0);
        t_tx(1'b0, 16'h3CA5);
        t_tx(1'b1, 16'hC35A);
        t_timeout();
        t_slow_link();
        chk("R8 no drive in rx end", rx_drive_cnt, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule